// File: doc/BRIEF.md
# Locked Two-Stage Watchdog Timer

This block is a watchdog for a large chip, reached through a small synchronous register bus with byte addresses. Software loads two preload values, configures what a timeout does, and enables counting. A down-counter first runs through stage 1, loaded from the first preload, then through stage 2, loaded from the second. When stage 2 runs out, the block sets a sticky timeout flag. It can also pulse a reset request and drive a timeout pin. Software keeps the system alive by reloading the counter before that happens.

Writes to the preloads and to the reload/flag register are protected. Each must come right after a two-byte key written to the key register. Any other write voids the key, and each protected write uses it up. A set-only lock bit freezes the configuration, the preloads and the lock register itself until the power-on reset. The block is reset only by that power-on input, never by the reset request it raises. The timeout flag therefore survives the system reset the watchdog causes.

Two state machines carry the function. The key tracker has states KEY_IDLE, KEY_HALF and KEY_OPEN:
- KEY_IDLE goes to KEY_HALF on 0x80 written to the key register.
- KEY_HALF goes to KEY_OPEN on 0x86 written there.
- Every other write returns the tracker to KEY_IDLE. A second 0x80 goes to KEY_HALF.

The stage machine has states CNT_STG1, CNT_STG2 and CNT_FIRED:
- CNT_STG1 goes to CNT_STG2 on a tick while the count is zero, and the count loads preload 2.
- CNT_STG2 goes to CNT_FIRED on a tick while the count is zero, and the block fires.
- A reload goes from any state to CNT_STG1 and loads preload 1.
- The count does not move in CNT_FIRED.

Top module: `wdt_guard`

## Requirements
- R1: A write to preload 1 (address 0x00), preload 2 (0x04) or the control register (0x0D) takes effect only when the two writes before it were 0x80 and then 0x86 to the key register (0x0C). Without the key the write is ignored.
- R2: The key is used up by one protected write. A write to any other address between the key and the protected write voids it, so that protected write is ignored.
- R3: While enabled, the count runs through stage 1 and then stage 2. CNT_FIRED is reached after (P1+1)+(P2+1) ticks, where P1 and P2 are the preloads. The down-counter readback at 0x14 shows 0 once the block has fired.
- R4: Timeout flag, bit 1 of the control register. It is set on firing and stays set. It is cleared only by a keyed write with bit 1 at 1. A write without the key leaves it set.
- R5: When config bit 4 is 1, firing raises rst_req for exactly RST_CYCLES clocks. When that bit is 0, rst_req stays low.
- R6: to_pin is high while the stage machine is in CNT_FIRED and config bit 5 is 1. It is low when bit 5 is 0.
- R7: Config bit 2 selects the tick rate: 1 gives one tick per 2^FINE_SHIFT clocks, 0 gives one tick per 2^COARSE_SHIFT clocks. The divider restarts on a reload and while counting is disabled.
- R8: Lock register (0x18) bit 0 locks. It can only be set from the bus. While it is set, writes to the config register (0x10), the preloads and the lock register are ignored, but keyed reloads still work. Only por_n clears it.
- R9: Lock register bit 1 enables counting. While it is 0 the counter holds its value, and a keyed reload still loads preload 1.
- R10: A keyed write with control bit 0 at 1 loads preload 1 into the counter and enters CNT_STG1. This leaves CNT_FIRED, so to_pin falls.
- R11: After por_n, every register reads 0, and rst_req and to_pin are low.
- R12: rst_cold follows config bit 3. It tells the system reset controller which kind of reset to perform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; the block's only reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data; key and control writes use bits 7:0 |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | Reset request pulse on timeout |
| rst_cold | output | 1 | Reset type selected by config bit 3 |
| to_pin | output | 1 | Timeout output pin |

## Verification
The bench builds the block with a 16-bit counter, FINE_SHIFT=1, COARSE_SHIFT=3 and RST_CYCLES=4. With these values a tick comes every 2 clocks in the fine mode and every 8 in the coarse mode. Full stage 1 and stage 2 runs, and the exact cycle of firing, can then be measured within a few dozen clocks in both modes. A 16-bit counter still leaves room to watch a held count far from zero, and the 4-clock pulse can be counted one clock at a time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_HALF,
        KEY_OPEN
    } key_st_t;

    typedef enum logic [1:0] {
        CNT_STG1,
        CNT_STG2,
        CNT_FIRED
    } cnt_st_t;

    localparam logic [7:0] A_PRE1 = 8'h00;
    localparam logic [7:0] A_PRE2 = 8'h04;
    localparam logic [7:0] A_KEY  = 8'h0C;
    localparam logic [7:0] A_CTL  = 8'h0D;
    localparam logic [7:0] A_CFG  = 8'h10;
    localparam logic [7:0] A_CNT  = 8'h14;
    localparam logic [7:0] A_LOCK = 8'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wbyte,
    output logic       key_open
);

    key_st_t st_q, st_d;

    // Next state: only writes move the tracker.
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (st_q)
                KEY_IDLE, KEY_OPEN: begin
                    if (addr == A_KEY && wbyte == KEY_FIRST) st_d = KEY_HALF;
                    else                                     st_d = KEY_IDLE;
                end
                KEY_HALF: begin
                    if (addr == A_KEY && wbyte == KEY_SECOND)     st_d = KEY_OPEN;
                    else if (addr == A_KEY && wbyte == KEY_FIRST) st_d = KEY_HALF;
                    else                                          st_d = KEY_IDLE;
                end
                default: st_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    always_comb key_open = (st_q == KEY_OPEN);

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
    parameter int FINE_SHIFT   = 5,
    parameter int COARSE_SHIFT = 15
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic clear,
    input  logic fine_sel,
    output logic tick
);

    localparam logic [COARSE_SHIFT-1:0] FINE_MASK =
        {COARSE_SHIFT{1'b1}} >> (COARSE_SHIFT - FINE_SHIFT);

    logic [COARSE_SHIFT-1:0] div_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)             div_q <= '0;
        else if (clear || !run) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    always_comb begin
        if (fine_sel) tick = run && !clear && ((div_q & FINE_MASK) == FINE_MASK);
        else          tick = run && !clear && (&div_q);
    end

endmodule

// File: rtl/wdt_stager.sv
module wdt_stager
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    input  logic             rst_en,
    input  logic             pin_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             rst_req,
    output logic             to_pin
);

    localparam int RW = $clog2(RST_CYCLES + 1);

    cnt_st_t          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;
    logic             flag_q;
    logic [RW-1:0]    rcnt_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (reload) begin
            st_d  = CNT_STG1;
            cnt_d = pre1;
        end else if (tick) begin
            unique case (st_q)
                CNT_STG1: begin
                    if (cnt_q == '0) begin
                        st_d  = CNT_STG2;
                        cnt_d = pre2;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                CNT_STG2: begin
                    if (cnt_q == '0) begin
                        st_d = CNT_FIRED;
                        fire = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                CNT_FIRED: st_d = CNT_FIRED;
                default:   st_d = CNT_STG1;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= CNT_STG1;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs: sticky flag and reset pulse length
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
            rcnt_q <= '0;
        end else begin
            if (fire)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (fire && rst_en)      rcnt_q <= RW'(RST_CYCLES);
            else if (rcnt_q != '0)   rcnt_q <= rcnt_q - 1'b1;
        end
    end

    always_comb begin
        cnt     = cnt_q;
        flag    = flag_q;
        rst_req = (rcnt_q != '0);
        to_pin  = (st_q == CNT_FIRED) && pin_en;
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int FINE_SHIFT   = 5,
    parameter int COARSE_SHIFT = 15,
    parameter int RST_CYCLES   = 4
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_we,
    output logic [31:0] bus_rdata,
    output logic        rst_req,
    output logic        rst_cold,
    output logic        to_pin
);

    logic             key_open;
    logic [CNT_W-1:0] pre1_q, pre2_q, cnt_w;
    logic [3:0]       cfg_q;      // {pin_en, rst_en, cold, fine}
    logic             lock_q, run_q, tocfg_q;
    logic             prot, pre1_wr, pre2_wr, ctl_wr, cfg_wr, lock_wr;
    logic             reload_stb, flag_clr, tick, flag_w;

    wdt_keygate u_key (
        .clk(clk), .por_n(por_n), .wr_en(bus_we), .addr(bus_addr),
        .wbyte(bus_wdata[7:0]), .key_open(key_open)
    );

    always_comb begin
        prot       = bus_we && key_open;
        pre1_wr    = prot && bus_addr == A_PRE1 && !lock_q;
        pre2_wr    = prot && bus_addr == A_PRE2 && !lock_q;
        ctl_wr     = prot && bus_addr == A_CTL;
        cfg_wr     = bus_we && bus_addr == A_CFG && !lock_q;
        lock_wr    = bus_we && bus_addr == A_LOCK && !lock_q;
        reload_stb = ctl_wr && bus_wdata[0];
        flag_clr   = ctl_wr && bus_wdata[1];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre1_q  <= '0;
            pre2_q  <= '0;
            cfg_q   <= '0;
            lock_q  <= 1'b0;
            run_q   <= 1'b0;
            tocfg_q <= 1'b0;
        end else begin
            if (pre1_wr) pre1_q <= bus_wdata[CNT_W-1:0];
            if (pre2_wr) pre2_q <= bus_wdata[CNT_W-1:0];
            if (cfg_wr)  cfg_q  <= bus_wdata[5:2];
            if (lock_wr) begin
                lock_q  <= lock_q | bus_wdata[0];
                run_q   <= bus_wdata[1];
                tocfg_q <= bus_wdata[2];
            end
        end
    end

    wdt_tick #(.FINE_SHIFT(FINE_SHIFT), .COARSE_SHIFT(COARSE_SHIFT)) u_tick (
        .clk(clk), .por_n(por_n), .run(run_q), .clear(reload_stb),
        .fine_sel(cfg_q[0]), .tick(tick)
    );

    wdt_stager #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_stage (
        .clk(clk), .por_n(por_n), .tick(tick), .reload(reload_stb),
        .pre1(pre1_q), .pre2(pre2_q), .rst_en(cfg_q[2]), .pin_en(cfg_q[3]),
        .flag_clr(flag_clr), .cnt(cnt_w), .flag(flag_w),
        .rst_req(rst_req), .to_pin(to_pin)
    );

    always_comb rst_cold = cfg_q[1];

    always_comb begin
        case (bus_addr)
            A_PRE1:  bus_rdata = 32'(pre1_q);
            A_PRE2:  bus_rdata = 32'(pre2_q);
            A_CTL:   bus_rdata = {30'b0, flag_w, 1'b0};
            A_CFG:   bus_rdata = {26'b0, cfg_q, 2'b0};
            A_CNT:   bus_rdata = 32'(cnt_w);
            A_LOCK:  bus_rdata = {29'b0, tocfg_q, run_q, lock_q};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RST_CYCLES = 4
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_req,
    input logic             flag,
    input logic             lock,
    input logic             run_en,
    input logic             reload,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] pre1,
    input logic             key_open,
    input logic             bus_we,
    input logic [7:0]       bus_addr
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 hi_cnt <= '0;
        else if (!rst_req)          hi_cnt <= '0;
        else if (hi_cnt != 8'hFF)   hi_cnt <= hi_cnt + 1'b1;
    end

    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
        hi_cnt <= 8'(RST_CYCLES)); // R5

    AST_RST_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_req) |-> flag); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        lock |=> lock); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!run_en && !reload) |=> $stable(cnt)); // R9

    AST_PRE_KEYED: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(pre1) |-> $past(key_open && bus_we && bus_addr == A_PRE1)); // R1

endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .flag(flag_w),
    .lock(lock_q), .run_en(run_q), .reload(reload_stb), .cnt(cnt_w),
    .pre1(pre1_q), .key_open(key_open), .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        rst_req, rst_cold, to_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wdt_guard #(.CNT_W(16), .FINE_SHIFT(1), .COARSE_SHIFT(3), .RST_CYCLES(4)) u0 (
        .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req),
        .rst_cold(rst_cold), .to_pin(to_pin)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic key();
        wr(8'h0C, 32'h80);
        wr(8'h0C, 32'h86);
    endtask

    task automatic cycles_to_pin(output int n);
        n = 0;
        while (!to_pin && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        int v;
        foreach (addr_list[i]) begin
            rd(addr_list[i], v);
            chk("R11 register after reset", v, 0);
        end
        chk("R11 rst_req after reset", int'(rst_req), 0);
        chk("R11 to_pin after reset", int'(to_pin), 0);
    endtask

    logic [7:0] addr_list [7] = '{8'h00, 8'h04, 8'h0C, 8'h0D, 8'h10, 8'h14, 8'h18};

    task automatic t_key();
        int v;
        wr(8'h00, 7);
        rd(8'h00, v); chk("R1 preload write without key", v, 0);
        key(); wr(8'h00, 5);
        rd(8'h00, v); chk("R1 keyed preload write", v, 5);
        wr(8'h00, 9);
        rd(8'h00, v); chk("R2 key used up", v, 5);
        key(); wr(8'h10, 0); wr(8'h00, 9);
        rd(8'h00, v); chk("R2 other write voids key", v, 5);
        key(); wr(8'h04, 3); wr(8'h04, 4);
        rd(8'h04, v); chk("R2 second protected write ignored", v, 3);
    endtask

    task automatic t_fine_fire();
        int v, n, r;
        wr(8'h10, 32'h34);
        key(); wr(8'h00, 3);
        key(); wr(8'h04, 2);
        key(); wr(8'h0D, 1);
        wr(8'h18, 32'h02);
        cycles_to_pin(n);
        chk("R3 R7 fine fire cycle (3,2)", n, 14);
        r = 0;
        while (rst_req && r < 20) begin
            r++;
            @(negedge clk);
        end
        chk("R5 rst_req pulse length", r, 4);
        rd(8'h0D, v); chk("R4 flag set on fire", v, 2);
        rd(8'h14, v); chk("R3 count readback after fire", v, 0);
        chk("R6 to_pin held while fired", int'(to_pin), 1);
        wr(8'h0D, 2);
        rd(8'h0D, v); chk("R4 flag kept without key", v, 2);
        key(); wr(8'h0D, 2);
        rd(8'h0D, v); chk("R4 keyed flag clear", v, 0);
        key(); wr(8'h0D, 1);
        chk("R10 reload leaves fired state", int'(to_pin), 0);
        cycles_to_pin(n);
        chk("R10 restart fires again", n, 14);
        wr(8'h18, 32'h00);
    endtask

    task automatic t_quiet_fire();
        int v, seen;
        wr(8'h10, 32'h04);
        key(); wr(8'h00, 0);
        key(); wr(8'h04, 0);
        key(); wr(8'h0D, 1);
        chk("R12 rst_cold low", int'(rst_cold), 0);
        wr(8'h18, 32'h02);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rst_req || to_pin) seen = 1;
        end
        chk("R5 R6 outputs quiet when disabled in config", seen, 0);
        rd(8'h0D, v); chk("R3 flag set with (0,0) preloads", v, 2);
        wr(8'h18, 32'h00);
        wr(8'h10, 32'h08);
        chk("R12 rst_cold high", int'(rst_cold), 1);
    endtask

    task automatic t_coarse();
        int n;
        wr(8'h10, 32'h30);
        key(); wr(8'h00, 3);
        key(); wr(8'h04, 2);
        key(); wr(8'h0D, 1);
        wr(8'h18, 32'h02);
        cycles_to_pin(n);
        chk("R7 coarse fire cycle (3,2)", n, 56);
        wr(8'h18, 32'h00);
    endtask

    task automatic t_hold();
        int c1, c2;
        wr(8'h10, 32'h24);
        key(); wr(8'h00, 50);
        key(); wr(8'h0D, 1);
        wr(8'h18, 32'h02);
        repeat (10) @(negedge clk);
        wr(8'h18, 32'h00);
        rd(8'h14, c1);
        chk("R9 counted while enabled", int'(c1 < 50 && c1 > 40), 1);
        repeat (20) @(negedge clk);
        rd(8'h14, c2);
        chk("R9 count held while disabled", c2, c1);
        key(); wr(8'h0D, 1);
        rd(8'h14, c2);
        chk("R9 reload while disabled", c2, 50);
    endtask

    task automatic t_lock();
        int v;
        wr(8'h18, 32'h03);
        rd(8'h18, v); chk("R8 lock readback", v, 3);
        wr(8'h10, 32'h00);
        rd(8'h10, v); chk("R8 config frozen", v, 32'h24);
        key(); wr(8'h00, 7);
        rd(8'h00, v); chk("R8 preload frozen", v, 50);
        wr(8'h18, 32'h00);
        rd(8'h18, v); chk("R8 lock register frozen", v, 3);
        repeat (6) @(negedge clk);
        key(); wr(8'h0D, 1);
        rd(8'h14, v); chk("R8 reload works while locked", v, 50);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        rd(8'h18, v); chk("R8 lock cleared by por_n", v, 0);
        rd(8'h10, v); chk("R11 config cleared by por_n", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_key();
        t_fine_fire();
        t_quiet_fire();
        t_coarse();
        t_hold();
        t_lock();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule